// File: doc/BRIEF.md
# Flag-Producing Add/Subtract Unit

This block is the integer add/subtract datapath of a processor execute stage. It has no clock and no state. It takes a destination operand, a source operand, an accumulator operand, a byte/word size select, an operation code and the current carry flag. From these it produces the values to write back to the destination, the source and the accumulator, one write enable for each, and six status flags: carry, auxiliary carry, zero, sign, parity and overflow.

Nine operations are covered:

- plain add and add-with-carry;
- plain subtract and subtract-with-borrow;
- compare;
- increment and decrement;
- exchange-and-add;
- compare-and-exchange against the accumulator.

The carry-in port is taken directly from the flag register. Two add-with-carry steps, or a subtract followed by a subtract-with-borrow, therefore chain word-wide operations into wider arithmetic.

Top module: `addsub_flag_unit`

## Requirements
- R1: Code 0 (add) writes the destination with dst+src and asserts only the destination write enable. Code 1 (add-with-carry) writes dst+src+carry_in in the same way. Carry is the carry out of the selected width.
- R2: Code 2 (subtract) writes dst-src to the destination. Code 3 (subtract-with-borrow) writes dst-src-carry_in. Carry is set on a borrow. Example, byte mode: 22h-44h gives DEh with C=1, A=1, Z=0, S=1, P=1, O=0.
- R3: Code 4 (compare) asserts no write enable. Its flags equal those of dst-src.
- R4: Code 5 (increment) writes dst+1. Code 6 (decrement) writes dst-1. Both update every flag except carry, which equals carry_in.
- R5: Parity is 1 when bits 7..0 of the result hold an even number of ones, in both sizes.
- R6: Auxiliary carry is the carry or borrow out of bit 3. Overflow is the signed overflow of the selected width. Zero and sign describe the result at the selected width.
- R7: Code 7 (exchange-and-add) writes dst+src to the destination and the original dst to the source. Only those two write enables are asserted. Flags are those of the add.
- R8: Code 8 (compare-and-exchange) takes its flags from acc-dst. If the two are equal, src goes to the destination with only the destination enable asserted. Otherwise, dst goes to the accumulator with only the accumulator enable asserted.
- R9: word_mode=0 selects byte size: operand bits 15..8 are ignored, carry and overflow are taken at bit 7, and every written value is zero-extended. word_mode=1 selects 16 bits.
- R10: Any write-back value whose enable is low reads zero. Codes 9 to 15 assert no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation code (0..8 valid) |
| word_mode | input | 1 | 1 = 16-bit, 0 = 8-bit |
| opa_dst | input | 16 | Destination operand |
| opb_src | input | 16 | Source operand |
| acc_in | input | 16 | Accumulator operand |
| carry_in | input | 1 | Current carry flag |
| dst_val | output | 16 | Value for the destination |
| dst_we | output | 1 | Destination write enable |
| src_val | output | 16 | Value for the source |
| src_we | output | 1 | Source write enable |
| acc_val | output | 16 | Value for the accumulator |
| acc_we | output | 1 | Accumulator write enable |
| cf | output | 1 | Carry / borrow flag |
| af | output | 1 | Auxiliary carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| pf | output | 1 | Parity flag |
| of | output | 1 | Overflow flag |

## Verification
Every output is combinational, so each result is due in the same cycle as the stimulus, zero clock edges later. The bench drives a new vector on each falling edge. It samples all outputs five nanoseconds later, well before the next rising edge, once the logic has settled. A 32-bit carry chain and a 32-bit borrow chain are run in two steps each: the carry sampled in the first step is fed back as carry_in for the second.

// File: rtl/addsub_flag_pkg.sv
package addsub_flag_pkg;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_XADD = 4'd7,
    OP_CMPX = 4'd8
  } op_e;

  typedef struct packed {
    logic valid;      // code is one of the nine operations
    logic subtract;   // invert second operand and borrow
    logic use_cin;    // carry_in participates
    logic keep_cf;    // carry flag passes through
    logic b_is_one;   // second operand is constant 1
    logic a_is_acc;   // first operand is the accumulator
    logic res_to_dst; // result written to destination
    logic xadd;       // source receives old destination
    logic cmpx;       // compare-and-exchange write-back
  } ctrl_t;

  typedef struct packed {
    logic c;
    logic a;
    logic z;
    logic s;
    logic p;
    logic o;
  } flags_t;
endpackage

// File: rtl/addsub_op_decode.sv
module addsub_op_decode
  import addsub_flag_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  output ctrl_t          ctrl
);
  always_comb begin
    ctrl = '0;
    case (op_code)
      OP_ADD:  begin ctrl.valid = 1'b1; ctrl.res_to_dst = 1'b1; end
      OP_ADC:  begin ctrl.valid = 1'b1; ctrl.res_to_dst = 1'b1; ctrl.use_cin = 1'b1; end
      OP_SUB:  begin ctrl.valid = 1'b1; ctrl.res_to_dst = 1'b1; ctrl.subtract = 1'b1; end
      OP_SBB:  begin ctrl.valid = 1'b1; ctrl.res_to_dst = 1'b1; ctrl.subtract = 1'b1;
                     ctrl.use_cin = 1'b1; end
      OP_CMP:  begin ctrl.valid = 1'b1; ctrl.subtract = 1'b1; end
      OP_INC:  begin ctrl.valid = 1'b1; ctrl.res_to_dst = 1'b1; ctrl.b_is_one = 1'b1;
                     ctrl.keep_cf = 1'b1; end
      OP_DEC:  begin ctrl.valid = 1'b1; ctrl.res_to_dst = 1'b1; ctrl.b_is_one = 1'b1;
                     ctrl.keep_cf = 1'b1; ctrl.subtract = 1'b1; end
      OP_XADD: begin ctrl.valid = 1'b1; ctrl.res_to_dst = 1'b1; ctrl.xadd = 1'b1; end
      OP_CMPX: begin ctrl.valid = 1'b1; ctrl.subtract = 1'b1; ctrl.a_is_acc = 1'b1;
                     ctrl.cmpx = 1'b1; end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         aux,
  output logic         ovf,
  output logic         zero,
  output logic         sign,
  output logic         parity
);
  localparam int unsigned NIB = 4;

  logic [W-1:0]   b_eff;
  logic           c_eff;
  logic [W:0]     full;
  logic [NIB:0]   low;

  always_comb begin
    b_eff  = subtract ? ~b : b;
    c_eff  = cin ^ subtract;
    full   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    low    = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
    res    = full[W-1:0];
    carry  = full[W] ^ subtract;
    aux    = low[NIB] ^ subtract;
    ovf    = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    zero   = (full[W-1:0] == '0);
    sign   = full[W-1];
    parity = ~^full[7:0];
  end
endmodule

// File: rtl/addsub_writeback.sv
module addsub_writeback
  import addsub_flag_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  ctrl_t        ctrl,
  input  logic [W-1:0] res,
  input  logic         equal,
  input  logic [W-1:0] dst_op,
  input  logic [W-1:0] src_op,
  output logic [W-1:0] dst_val,
  output logic         dst_we,
  output logic [W-1:0] src_val,
  output logic         src_we,
  output logic [W-1:0] acc_val,
  output logic         acc_we
);
  always_comb begin
    dst_we  = ctrl.res_to_dst | (ctrl.cmpx & equal);
    src_we  = ctrl.xadd;
    acc_we  = ctrl.cmpx & ~equal;
    dst_val = '0;
    if (ctrl.res_to_dst)           dst_val = res;
    else if (ctrl.cmpx && equal)   dst_val = src_op;
    src_val = src_we ? dst_op : '0;
    acc_val = acc_we ? dst_op : '0;
  end
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_flag_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned BW = 8
) (
  input  logic [3:0]   op_code,
  input  logic         word_mode,
  input  logic [15:0]  opa_dst,
  input  logic [15:0]  opb_src,
  input  logic [15:0]  acc_in,
  input  logic         carry_in,
  output logic [15:0]  dst_val,
  output logic         dst_we,
  output logic [15:0]  src_val,
  output logic         src_we,
  output logic [15:0]  acc_val,
  output logic         acc_we,
  output logic         cf,
  output logic         af,
  output logic         zf,
  output logic         sf,
  output logic         pf,
  output logic         of
);
  localparam int unsigned NSZ = 2;  // byte and word lanes

  ctrl_t        ctrl;
  logic [W-1:0] a_sel, b_sel, dst_m, src_m;
  logic         cin_sel;
  logic [W-1:0] res_lane [NSZ];
  logic [NSZ-1:0] c_l, a_l, o_l, z_l, s_l, p_l;
  logic [W-1:0] res_m;
  flags_t       fl;

  addsub_op_decode u_dec (.op_code(op_code), .ctrl(ctrl));

  always_comb begin
    dst_m   = word_mode ? opa_dst : {{(W-BW){1'b0}}, opa_dst[BW-1:0]};
    src_m   = word_mode ? opb_src : {{(W-BW){1'b0}}, opb_src[BW-1:0]};
    a_sel   = ctrl.a_is_acc ? acc_in : opa_dst;
    b_sel   = ctrl.b_is_one ? W'(1) : (ctrl.a_is_acc ? opa_dst : opb_src);
    cin_sel = ctrl.use_cin & carry_in;
  end

  for (genvar g = 0; g < NSZ; g++) begin : g_lane
    localparam int unsigned LW = (g == 0) ? BW : W;
    logic [LW-1:0] r;
    addsub_core #(.W(LW)) u_core (
      .a(a_sel[LW-1:0]), .b(b_sel[LW-1:0]), .subtract(ctrl.subtract),
      .cin(cin_sel), .res(r), .carry(c_l[g]), .aux(a_l[g]), .ovf(o_l[g]),
      .zero(z_l[g]), .sign(s_l[g]), .parity(p_l[g])
    );
    if (LW < W) begin : g_ext
      assign res_lane[g] = {{(W-LW){1'b0}}, r};
    end else begin : g_full
      assign res_lane[g] = r;
    end
  end

  always_comb begin
    res_m = word_mode ? res_lane[1] : res_lane[0];
    fl.c  = ctrl.keep_cf ? carry_in : c_l[word_mode];
    fl.a  = a_l[word_mode];
    fl.z  = z_l[word_mode];
    fl.s  = s_l[word_mode];
    fl.p  = p_l[word_mode];
    fl.o  = o_l[word_mode];
    cf = fl.c; af = fl.a; zf = fl.z; sf = fl.s; pf = fl.p; of = fl.o;
  end

  addsub_writeback #(.W(W)) u_wb (
    .ctrl(ctrl), .res(res_m), .equal(fl.z), .dst_op(dst_m), .src_op(src_m),
    .dst_val(dst_val), .dst_we(dst_we), .src_val(src_val), .src_we(src_we),
    .acc_val(acc_val), .acc_we(acc_we)
  );
endmodule

// File: rtl/addsub_flag_chk.sv
module addsub_flag_chk (
  input logic [3:0]  op_code,
  input logic        word_mode,
  input logic [15:0] opa_dst,
  input logic        carry_in,
  input logic [15:0] dst_val,
  input logic        dst_we,
  input logic [15:0] src_val,
  input logic        src_we,
  input logic        acc_we,
  input logic        cf,
  input logic        zf,
  input logic        pf
);
  always_comb begin
    if (op_code == 4'd4)
      a_r3_cmp_no_write: assert (!dst_we && !src_we && !acc_we)
        else $error("R3 compare wrote back");
    if (op_code == 4'd5 || op_code == 4'd6)
      a_r4_carry_kept: assert (cf == carry_in)
        else $error("R4 carry changed");
    if (op_code == 4'd0)
      a_r5_parity: assert (pf == ~^dst_val[7:0])
        else $error("R5 parity mismatch");
    if (op_code == 4'd0)
      a_r6_zero: assert (zf == (dst_val == 16'h0))
        else $error("R6 zero mismatch");
    if (op_code == 4'd7)
      a_r7_xadd_src: assert (src_we && src_val ==
                             (word_mode ? opa_dst : {8'h00, opa_dst[7:0]}))
        else $error("R7 exchange source wrong");
    if (op_code == 4'd8)
      a_r8_one_target: assert (dst_we != acc_we)
        else $error("R8 write enables");
    if (!word_mode)
      a_r9_byte_ext: assert (dst_val[15:8] == 8'h00)
        else $error("R9 upper byte set");
    if (op_code > 4'd8)
      a_r10_no_write: assert (!dst_we && !src_we && !acc_we)
        else $error("R10 unused code wrote");
  end
endmodule

bind addsub_flag_unit addsub_flag_chk u_chk (.*);

// File: tb/tb_addsub_flag_unit.sv
module tb_addsub_flag_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  op_code;
  logic        word_mode, carry_in;
  logic [15:0] opa_dst, opb_src, acc_in;
  logic [15:0] dst_val, src_val, acc_val;
  logic        dst_we, src_we, acc_we, cf, af, zf, sf, pf, of;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  addsub_flag_unit dut (.*);

  task automatic drive(input logic [3:0] op, input logic w, input logic [15:0] d,
                       input logic [15:0] s, input logic [15:0] a, input logic c);
    @(negedge clk);
    op_code = op; word_mode = w; opa_dst = d; opb_src = s; acc_in = a; carry_in = c;
    #5;
  endtask

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Apply one vector and compare every output against a model built from the requirements.
  task automatic run(input logic [3:0] op, input logic w, input logic [15:0] d,
                     input logic [15:0] s, input logic [15:0] a, input logic c,
                     input string req);
    int m, half, x, y, ci, r, ln, sx, sy, sr;
    bit sub, valid, kc;
    logic [15:0] res, e_dv, e_sv, e_av;
    logic e_dw, e_sw, e_aw, e_c, e_a, e_z, e_s, e_p, e_o;
    m = w ? 16'hFFFF : 16'h00FF;
    half = w ? 32768 : 128;
    x = int'(d) & m; y = int'(s) & m; ci = 0; sub = 0; valid = 1; kc = 0;
    case (op)
      4'd0: ;
      4'd1: ci = int'(c);
      4'd2: sub = 1;
      4'd3: begin sub = 1; ci = int'(c); end
      4'd4: sub = 1;
      4'd5: begin y = 1; kc = 1; end
      4'd6: begin y = 1; kc = 1; sub = 1; end
      4'd7: ;
      4'd8: begin x = int'(a) & m; y = int'(d) & m; sub = 1; end
      default: valid = 0;
    endcase
    r   = sub ? x - y - ci : x + y + ci;
    ln  = sub ? (x & 15) - (y & 15) - ci : (x & 15) + (y & 15) + ci;
    sx  = (x >= half) ? x - (m + 1) : x;
    sy  = (y >= half) ? y - (m + 1) : y;
    sr  = sub ? sx - sy - ci : sx + sy + ci;
    res = 16'(r & m);
    e_c = kc ? c : (sub ? (r < 0) : (r > m));
    e_a = (ln < 0) || (ln > 15);
    e_o = (sr >= half) || (sr < -half);
    e_z = (res == 16'h0);
    e_s = w ? res[15] : res[7];
    e_p = ~^res[7:0];
    e_dw = 0; e_sw = 0; e_aw = 0; e_dv = 0; e_sv = 0; e_av = 0;
    if (valid && op != 4'd4 && op != 4'd8) begin e_dw = 1; e_dv = res; end
    if (op == 4'd7) begin e_sw = 1; e_sv = 16'(int'(d) & m); end
    if (op == 4'd8) begin
      if (e_z) begin e_dw = 1; e_dv = 16'(int'(s) & m); end
      else begin e_aw = 1; e_av = 16'(int'(d) & m); end
    end
    drive(op, w, d, s, a, c);
    check({dst_we, src_we, acc_we, dst_val, src_val, acc_val} ==
          {e_dw, e_sw, e_aw, e_dv, e_sv, e_av}, req,
          $sformatf("op%0d w%0d wb act=%b%b%b %h %h %h exp=%b%b%b %h %h %h", op, w,
                    dst_we, src_we, acc_we, dst_val, src_val, acc_val,
                    e_dw, e_sw, e_aw, e_dv, e_sv, e_av));
    if (valid)
      check({cf, af, zf, sf, pf, of} == {e_c, e_a, e_z, e_s, e_p, e_o}, req,
            $sformatf("op%0d w%0d d=%h s=%h a=%h c=%b flags CAZSPO act=%b%b%b%b%b%b exp=%b%b%b%b%b%b",
                      op, w, d, s, a, c, cf, af, zf, sf, pf, of,
                      e_c, e_a, e_z, e_s, e_p, e_o));
  endtask

  task automatic t_reset_state;  // R1 R6: all-zero inputs
    run(4'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, "R1");
  endtask

  task automatic t_add;  // R1
    run(4'd0, 1'b0, 16'h007F, 16'h0001, 16'h0, 1'b0, "R1");
    run(4'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0, 1'b1, "R1");
    run(4'd1, 1'b0, 16'h00FF, 16'h0000, 16'h0, 1'b1, "R1");
  endtask

  task automatic t_adc_chain;  // R1: 0001FFFF + 00000001
    logic c0; logic [15:0] lo;
    drive(4'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0, 1'b0);
    lo = dst_val; c0 = cf;
    drive(4'd1, 1'b1, 16'h0001, 16'h0000, 16'h0, c0);
    check({dst_val, lo} == 32'h0002_0000, "R1",
          $sformatf("32-bit add act=%h%h exp=00020000", dst_val, lo));
  endtask

  task automatic t_sub;  // R2
    drive(4'd2, 1'b0, 16'h0022, 16'h0044, 16'h0, 1'b0);
    check({dst_val, cf, af, zf, sf, pf, of} == {16'h00DE, 6'b110110}, "R2",
          $sformatf("22-44 act=%h %b%b%b%b%b%b exp=00de 110110",
                    dst_val, cf, af, zf, sf, pf, of));
    run(4'd3, 1'b1, 16'h8000, 16'h0001, 16'h0, 1'b1, "R2");
  endtask

  task automatic t_sbb_chain;  // R2: 00010000 - 00000001
    logic c0; logic [15:0] lo;
    drive(4'd2, 1'b1, 16'h0000, 16'h0001, 16'h0, 1'b0);
    lo = dst_val; c0 = cf;
    drive(4'd3, 1'b1, 16'h0001, 16'h0000, 16'h0, c0);
    check({dst_val, lo} == 32'h0000_FFFF, "R2",
          $sformatf("32-bit sub act=%h%h exp=0000ffff", dst_val, lo));
  endtask

  task automatic t_cmp;  // R3
    run(4'd4, 1'b0, 16'h0010, 16'h0010, 16'h0, 1'b0, "R3");
    run(4'd4, 1'b1, 16'h0001, 16'h8000, 16'h0, 1'b1, "R3");
  endtask

  task automatic t_incdec;  // R4
    run(4'd5, 1'b0, 16'h00FF, 16'h1234, 16'h0, 1'b0, "R4");
    run(4'd5, 1'b1, 16'h7FFF, 16'h0, 16'h0, 1'b1, "R4");
    run(4'd6, 1'b0, 16'h0000, 16'h0, 16'h0, 1'b0, "R4");
    run(4'd6, 1'b1, 16'h8000, 16'h0, 16'h0, 1'b1, "R4");
  endtask

  task automatic t_parity_aux;  // R5 R6
    run(4'd0, 1'b1, 16'h0F00, 16'h0003, 16'h0, 1'b0, "R5");
    run(4'd0, 1'b0, 16'h000F, 16'h0001, 16'h0, 1'b0, "R6");
    run(4'd2, 1'b0, 16'h0080, 16'h0001, 16'h0, 1'b0, "R6");
  endtask

  task automatic t_xadd;  // R7
    drive(4'd7, 1'b0, 16'h0012, 16'h0002, 16'h0, 1'b0);
    check({dst_we, dst_val, src_we, src_val, acc_we} == {1'b1, 16'h0014, 1'b1, 16'h0012, 1'b0},
          "R7", $sformatf("xadd act=%h %h exp=0014 0012", dst_val, src_val));
    run(4'd7, 1'b1, 16'hFFFF, 16'h8000, 16'h0, 1'b0, "R7");
  endtask

  task automatic t_cmpx;  // R8
    drive(4'd8, 1'b1, 16'h1234, 16'hABCD, 16'h1234, 1'b0);
    check({dst_we, dst_val, acc_we, acc_val, zf} == {1'b1, 16'hABCD, 1'b0, 16'h0, 1'b1},
          "R8", $sformatf("equal act=%b %h %b %h exp=1 abcd 0 0000", dst_we, dst_val, acc_we, acc_val));
    drive(4'd8, 1'b1, 16'h1234, 16'hABCD, 16'h1235, 1'b0);
    check({dst_we, dst_val, acc_we, acc_val, zf} == {1'b0, 16'h0, 1'b1, 16'h1234, 1'b0},
          "R8", $sformatf("differ act=%b %h %b %h exp=0 0000 1 1234", dst_we, dst_val, acc_we, acc_val));
    run(4'd8, 1'b0, 16'hAA55, 16'h0077, 16'h3355, 1'b0, "R8");
  endtask

  task automatic t_byte_mode;  // R9
    drive(4'd0, 1'b0, 16'hAB80, 16'hCD80, 16'h0, 1'b0);
    check({dst_val, cf, of, zf} == {16'h0000, 3'b111}, "R9",
          $sformatf("byte 80+80 act=%h c%b o%b z%b exp=0000 1 1 1", dst_val, cf, of, zf));
    run(4'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h0, 1'b0, "R9");
  endtask

  task automatic t_unused;  // R10
    for (int k = 9; k < 16; k++) run(4'(k), 1'b1, 16'hFFFF, 16'h1111, 16'h2222, 1'b1, "R10");
  endtask

  task automatic t_random;  // R1..R9 on random and edge operands
    logic [15:0] edges [6] = '{16'h0000, 16'h007F, 16'h0080, 16'h00FF, 16'h8000, 16'hFFFF};
    for (int i = 0; i < 300; i++) begin
      logic [15:0] d, s;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      d = (i % 3 == 0) ? edges[seed[2:0] % 6] : seed[15:0];
      s = (i % 4 == 0) ? edges[seed[5:3] % 6] : seed[31:16];
      run(4'(i % 9), seed[7], d, s, (i % 5 == 0) ? d : seed[23:8], seed[9], "R6");
    end
  endtask

  initial begin
    op_code = 4'd0; word_mode = 1'b0; opa_dst = '0; opb_src = '0; acc_in = '0; carry_in = 1'b0;
    t_reset_state();
    t_add();
    t_adc_chain();
    t_sub();
    t_sbb_chain();
    t_cmp();
    t_incdec();
    t_parity_aux();
    t_xadd();
    t_cmpx();
    t_byte_mode();
    t_unused();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule